// File: doc/BRIEF.md
# Timed Switch Light Controller

This block steps a lamp through three brightness settings from one push-button. A single-cycle pulse from a debounced button is the only input. The block keeps a cycle counter that measures the time since the most recent press. From that counter it decides whether the next press is quick, which raises the lamp to full brightness, or late, which switches the lamp off. The lamp setting and the controller state leave the block as registered two-bit codes. Downstream logic, such as a dimming modulator or a lamp driver, decodes these codes.

The quick window is a parameter counted in clock cycles. The counter stops at the window length and never wraps. Because of this, a press that follows a very long idle gap is always treated as late. Reset is synchronous and active high.

Top module: `lamp_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears its state and its gap counter. From the next cycle on, `state_o` reads 00 and `level_o` reads 00 (off). This holds even when a press arrives at the same edge.
- R2: A press sampled while the state is off moves the state to dim (`state_o` = 01) and restarts the gap counter. Every sampled press restarts the counter, whatever the state.
- R3: Take a press sampled while dim at edge k+d, where the previous press was sampled at edge k. If d ≤ THRESH (default 16), the press moves the state to bright (`state_o` = 10). In this case the counter, which reads d−1 at that edge, is strictly below THRESH.
- R4: A press sampled while dim with d > THRESH turns the lamp off (`state_o` = 00).
- R5: A press sampled while bright turns the lamp off, whatever the gap.
- R6: The gap counter saturates at THRESH. A press while dim after a gap long enough to wrap a free-running counter (for example 40 cycles with THRESH = 16) still counts as late and turns the lamp off.
- R7: Each press pulse causes exactly one transition. In a cycle with no press, `state_o` and `level_o` hold their values.
- R8: `level_o` is a registered code: 00 off, 01 dim, 10 bright. It changes in the same cycle as `state_o`, one edge after the press is sampled, and always agrees with the state. `state_o` uses the same codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| press_i | input | 1 | One-cycle button pulse, already debounced |
| level_o | output | 2 | Registered lamp level: 00 off, 01 dim, 10 bright |
| state_o | output | 2 | Current controller state: 00 off, 01 dim, 10 bright |

## Verification
Every result of this block is due exactly one edge after the edge that samples the press or the reset. This applies to the new state, the new level code, and the counter restart. The quick/late decision uses the counter value as it stands at the press edge, which equals the gap in edges minus one. The bench drives `press_i` and `rst` on falling edges and advances its behavioural model on each rising edge. It then compares both outputs on the following falling edge, so every comparison lands in the cycle where the result has to be visible. The directed gaps put presses at d = THRESH and d = THRESH + 1, back-to-back at d = 1, and at a gap of 40 that would wrap an unsaturated counter.

// File: rtl/lamp_pkg.sv
package lamp_pkg;

    typedef enum logic [1:0] {
        LS_OFF    = 2'b00,
        LS_DIM    = 2'b01,
        LS_BRIGHT = 2'b10
    } lamp_state_e;

    typedef logic [1:0] lamp_level_t;

    localparam lamp_level_t LVL_OFF    = 2'b00;
    localparam lamp_level_t LVL_DIM    = 2'b01;
    localparam lamp_level_t LVL_BRIGHT = 2'b10;

    function automatic lamp_level_t level_of(input lamp_state_e s);
        lamp_level_t l;
        case (s)
            LS_DIM:    l = LVL_DIM;
            LS_BRIGHT: l = LVL_BRIGHT;
            default:   l = LVL_OFF;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/lamp_gap_timer.sv
module lamp_gap_timer #(
    parameter int THRESH = 16,
    parameter int CNT_W  = $clog2(THRESH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart_i,
    output logic [CNT_W-1:0] elapsed_o,
    output logic             quick_o
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THRESH);
    localparam logic [CNT_W-1:0] STEP  = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } timer_regs_t;

    timer_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (restart_i) begin
            r_d.count = '0;
        end else if (r_q.count < LIMIT) begin
            r_d.count = r_q.count + STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign elapsed_o = r_q.count;
    assign quick_o   = (r_q.count < LIMIT);

endmodule

// File: rtl/lamp_step_fsm.sv
module lamp_step_fsm
    import lamp_pkg::*;
(
    input  lamp_state_e state_i,
    input  logic        press_i,
    input  logic        quick_i,
    output lamp_state_e state_o
);

    always_comb begin
        state_o = state_i;
        if (press_i) begin
            case (state_i)
                LS_OFF:    state_o = LS_DIM;
                LS_DIM:    state_o = quick_i ? LS_BRIGHT : LS_OFF;
                LS_BRIGHT: state_o = LS_OFF;
                default:   state_o = LS_OFF;
            endcase
        end
    end

endmodule

// File: rtl/lamp_level_reg.sv
module lamp_level_reg
    import lamp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  lamp_state_e next_state_i,
    output lamp_level_t level_o
);

    typedef struct packed {
        lamp_level_t level;
    } level_regs_t;

    level_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.level = level_of(next_state_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{level: LVL_OFF};
        end else begin
            r_q <= r_d;
        end
    end

    assign level_o = r_q.level;

endmodule

// File: rtl/lamp_ctrl.sv
module lamp_ctrl
    import lamp_pkg::*;
#(
    parameter int THRESH = 16,
    localparam int CNT_W = $clog2(THRESH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       press_i,
    output logic [1:0] level_o,
    output logic [1:0] state_o
);

    typedef struct packed {
        lamp_state_e state;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;

    logic [CNT_W-1:0] elapsed_w;
    logic             quick_w;
    lamp_state_e      step_w;
    lamp_level_t      level_w;

    lamp_gap_timer #(
        .THRESH (THRESH),
        .CNT_W  (CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .restart_i (press_i),
        .elapsed_o (elapsed_w),
        .quick_o   (quick_w)
    );

    lamp_step_fsm u_step (
        .state_i (r_q.state),
        .press_i (press_i),
        .quick_i (quick_w),
        .state_o (step_w)
    );

    always_comb begin
        r_d       = r_q;
        r_d.state = step_w;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{state: LS_OFF};
        end else begin
            r_q <= r_d;
        end
    end

    lamp_level_reg u_level (
        .clk          (clk),
        .rst          (rst),
        .next_state_i (r_d.state),
        .level_o      (level_w)
    );

    assign level_o = level_w;
    assign state_o = r_q.state;

endmodule

// File: rtl/lamp_ctrl_chk.sv
module lamp_ctrl_chk #(
    parameter int THRESH = 16,
    parameter int CNT_W  = $clog2(THRESH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             press_i,
    input logic [1:0]       level_o,
    input logic [1:0]       state_o,
    input logic [CNT_W-1:0] elapsed
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THRESH);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (state_o == 2'b00 && level_o == 2'b00 && elapsed == '0)); // R1

    AST_OFF_TO_DIM: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b00 && press_i) |=> (state_o == 2'b01)); // R2

    AST_PRESS_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        press_i |=> (elapsed == '0)); // R2

    AST_DIM_QUICK: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b01 && press_i && elapsed < LIMIT) |=> (state_o == 2'b10)); // R3

    AST_DIM_LATE: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b01 && press_i && elapsed >= LIMIT) |=> (state_o == 2'b00)); // R4

    AST_BRIGHT_OFF: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b10 && press_i) |=> (state_o == 2'b00)); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        elapsed <= LIMIT); // R6

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !press_i |=> ($stable(state_o) && $stable(level_o))); // R7

    AST_LEVEL_AGREES: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (level_o == state_o && level_o != 2'b11)); // R8

endmodule

bind lamp_ctrl lamp_ctrl_chk #(
    .THRESH (THRESH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .press_i (press_i),
    .level_o (level_o),
    .state_o (state_o),
    .elapsed (elapsed_w)
);

// File: tb/lamp_ctrl_test.sv
module lamp_ctrl_test;

    localparam int T = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       press_i = 1'b0;
    logic [1:0] level_o;
    logic [1:0] state_o;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    int    m_state = 0;
    int    m_cnt = 0;
    int    m_gap = 0;
    string m_tag = "R1";

    lamp_ctrl #(.THRESH(T)) uut (
        .clk     (clk),
        .rst     (rst),
        .press_i (press_i),
        .level_o (level_o),
        .state_o (state_o)
    );

    always #2.5 clk = ~clk;

    // Behavioural reference: advances on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_cnt = 0; m_gap = 0; m_tag = "R1";
        end else if (press_i) begin
            case (m_state)
                0: begin m_state = 1; m_tag = "R2"; end
                1: begin
                    if (m_cnt < T) begin m_state = 2; m_tag = "R3"; end
                    else begin m_state = 0; m_tag = (m_gap > 2 * T) ? "R6" : "R4"; end
                end
                default: begin m_state = 0; m_tag = "R5"; end
            endcase
            m_cnt = 0; m_gap = 1;
        end else begin
            m_tag = "R7";
            if (m_cnt < T) m_cnt = m_cnt + 1;
            m_gap = m_gap + 1;
        end
    end

    // Compare both outputs on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            total = total + 1;
            if (state_o !== 2'(m_state)) begin
                bad = bad + 1;
                $display("FAIL %s state: actual=%0d expected=%0d at %0t", m_tag, state_o, m_state, $time);
            end
            total = total + 1;
            if (level_o !== 2'(m_state)) begin // R8 level code equals state code
                bad = bad + 1;
                $display("FAIL R8 level: actual=%0d expected=%0d at %0t", level_o, m_state, $time);
            end
        end
    end

    task automatic hit(input int d);
        repeat (d - 1) begin
            @(negedge clk);
            press_i = 1'b0;
        end
        @(negedge clk);
        press_i = 1'b1;
    endtask

    task automatic hold_reset(input int n);
        @(negedge clk);
        press_i = 1'b1;   // R1: press at a reset edge is ignored
        rst = 1'b1;
        repeat (n) @(negedge clk);
        press_i = 1'b0;
        rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        hit(5);        // R2 off -> dim
        hit(T);        // R3 boundary d = THRESH -> bright
        hit(3);        // R5 bright -> off
        hit(2);        // R2
        hit(T + 1);    // R4 boundary d = THRESH+1 -> off
        hit(1);        // R2
        hit(1);        // R3 back-to-back -> bright
        hit(4);        // R5
        hit(2);        // R2
        hit(40);       // R6 gap that would wrap an unsaturated counter
        hit(2);        // R2
        hit(5);        // R3
        hold_reset(2); // R1 mid-run reset while bright
        hit(3);        // R2 after reset
        hit(3);        // R3
        @(negedge clk);
        press_i = 1'b0;
        repeat (20) @(negedge clk); // R7 idle hold
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule